// File: doc/BRIEF.md
# Branchless Logarithm-Table Multiplier for GF(2^8)

This block multiplies two bytes as elements of the finite field GF(2^8). The field is built on the polynomial x^8+x^4+x^3+x^2+1, and x is its generator. Each operand is first turned into its discrete logarithm. The two logarithms are then added, and the sum is turned back into a field element with an antilogarithm table. Both tables are computed during elaboration from the polynomial, so the design holds no table contents written out by hand.

The product needs neither a modulo step nor a test for zero. The antilogarithm table repeats the cycle of 255 powers, so any sum of two logarithms of nonzero bytes (at most 508) addresses it directly. The logarithm of zero is coded as 512. Every antilogarithm entry from 512 up to 1024 holds zero. As a result, any sum that involves a zero operand reads a zero.

The multiplier is a two-stage pipeline. It accepts one operand pair per clock, each marked by a valid strobe. It is used wherever a stream of coefficient-times-data products is needed, for example in erasure-code encoding.

Top module: `gf_logexp_mul`

## Requirements
- R1: While rst_n is low and after its release, out_valid is 0 and out_prod is 0x00 until the first result arrives.
- R2: A pair presented with in_valid high at a rising edge gives out_valid high after exactly two rising edges. out_valid is low in every cycle whose slot two edges earlier had in_valid low.
- R3: For every pair (a, b) of bytes, out_prod equals the GF(2^8) product reduced by the polynomial 0x11D. Bit i of a byte is the coefficient of x^i.
- R4: When either operand is 0x00, out_prod is 0x00.
- R5: When operand a is 0x01, out_prod equals operand b.
- R6: Swapping the two operands gives the same out_prod.
- R7: While out_valid is low, out_prod keeps the value of the last valid result.
- R8: 0x09 times 0x0C gives 0x6C, and 0x02 times 0x80 gives 0x1D.
- R9: Back-to-back pairs, with in_valid high in consecutive cycles, each give their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks in_a and in_b as a pair to multiply |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| out_valid | output | 1 | Marks out_prod as a new result |
| out_prod | output | 8 | Field product of the pair accepted two edges earlier |

## Verification
Every result is due two rising edges after its pair is sampled. The bench drives on falling edges and keeps a two-deep shadow of what it drove. At each falling edge it compares out_valid and out_prod with the entry driven two falling edges before. Where that entry carried no valid pair, it instead checks that the output is low and still holds the last product. All 65536 pairs are streamed back to back against a shift-and-XOR reference. Idle gaps are placed between bursts.

// File: rtl/gf_logexp_mul.sv
module gf_logexp_mul (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_a,
  input  logic [7:0] in_b,
  output logic       out_valid,
  output logic [7:0] out_prod
);

  localparam int          W       = 8;
  localparam logic [W-1:0] RED    = 8'h1d;
  localparam int          ORDER   = (1 << W) - 1;
  localparam int          ZLOG    = 2 << W;
  localparam int          EXP_N   = 2 * ZLOG + 1;
  localparam int          LOG_W   = 16;
  localparam int          IDX_W   = $clog2(EXP_N);

  function automatic logic [W-1:0] mul_x(input logic [W-1:0] e);
    return {e[W-2:0], 1'b0} ^ (e[W-1] ? RED : '0);
  endfunction

  function automatic logic [W-1:0] pow_gen(input int idx);
    logic [W-1:0] e;
    e = 1;
    if (idx >= ZLOG) return '0;
    for (int j = 0; j < idx % ORDER; j++) e = mul_x(e);
    return e;
  endfunction

  function automatic logic [LOG_W-1:0] log_of(input int v);
    logic [W-1:0]     e;
    logic [LOG_W-1:0] r;
    e = 1;
    r = LOG_W'(ZLOG);
    for (int j = 0; j < ORDER; j++) begin
      if (v != 0 && e == W'(v) && r == LOG_W'(ZLOG)) r = LOG_W'(j);
      e = mul_x(e);
    end
    return r;
  endfunction

  logic [LOG_W-1:0] log_tab [0:ORDER];
  logic [W-1:0]     exp_tab [0:EXP_N-1];

  for (genvar v = 0; v <= ORDER; v++) begin : g_log
    localparam logic [LOG_W-1:0] LV = log_of(v);
    assign log_tab[v] = LV;
  end

  for (genvar i = 0; i < EXP_N; i++) begin : g_exp
    localparam logic [W-1:0] EV = pow_gen(i);
    assign exp_tab[i] = EV;
  end

  logic             v1_q;
  logic [LOG_W-1:0] la_q, lb_q;
  logic [LOG_W-1:0] lsum;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      la_q <= '0;
      lb_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        la_q <= log_tab[in_a];
        lb_q <= log_tab[in_b];
      end
    end
  end

  assign lsum = la_q + lb_q;
  assign idx  = lsum[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) out_prod <= exp_tab[idx];
    end
  end

  // R2
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1_q);

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_valid);

  // R3
  log_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a != 8'h00) |=> (la_q < LOG_W'(ORDER)));

  // R4
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a == 8'h00 || in_b == 8'h00)) |=> ##1 (out_prod == 8'h00));

  // R5
  unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a == 8'h01) |=> ##1 (out_prod == $past(in_b, 2)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(out_prod));

endmodule

// File: tb/gf_logexp_mul_tb.sv
module gf_logexp_mul_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_a = 8'h00;
  logic [7:0] in_b = 8'h00;
  logic       out_valid;
  logic [7:0] out_prod;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  logic       d1_v = 1'b0, d2_v = 1'b0;
  logic [7:0] d1_p = 8'h00, d2_p = 8'h00;
  logic [7:0] held = 8'h00;

  always #2.5 clk = ~clk;

  gf_logexp_mul u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_prod(out_prod)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    logic       c;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      c = x[7];
      x = x << 1;
      if (c) x ^= 8'h1d;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b, input string req);
    @(negedge clk);
    check("R2", {8'h00, out_valid}, {8'h00, d2_v});
    if (d2_v) begin
      check(req, {1'b0, out_prod}, {1'b0, d2_p});
      held = d2_p;
    end else begin
      check("R7", {1'b0, out_prod}, {1'b0, held});
    end
    d2_v = d1_v;
    d2_p = d1_p;
    d1_v = v;
    d1_p = ref_mul(a, b);
    in_valid = v;
    in_a = a;
    in_b = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {out_valid, out_prod}, 9'h000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, out_prod}, 9'h000);

    step(1'b1, 8'h09, 8'h0C, "R8");
    step(1'b1, 8'h02, 8'h80, "R8");
    step(1'b0, 8'h55, 8'hAA, "R7");
    step(1'b0, 8'h33, 8'h44, "R7");
    step(1'b0, 8'h00, 8'h00, "R7");
    step(1'b1, 8'h00, 8'hFF, "R4");
    step(1'b1, 8'hFF, 8'h00, "R4");
    step(1'b1, 8'h00, 8'h00, "R4");
    step(1'b1, 8'h01, 8'hB7, "R5");
    step(1'b1, 8'h01, 8'h00, "R5");
    step(1'b1, 8'h53, 8'hCA, "R6");
    step(1'b1, 8'hCA, 8'h53, "R6");
    step(1'b0, 8'h12, 8'h34, "R7");
    step(1'b0, 8'h12, 8'h34, "R7");

    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        step(1'b1, 8'(a), 8'(b), "R3 R9");
      end
      if (a % 64 == 63) begin
        step(1'b0, 8'hA5, 8'h5A, "R7");
        step(1'b0, 8'hA5, 8'h5A, "R7");
      end
    end

    step(1'b0, 8'h00, 8'h00, "R7");
    step(1'b0, 8'h00, 8'h00, "R7");
    step(1'b0, 8'h00, 8'h00, "R7");
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule